// File: doc/BRIEF.md
# Frame Boundary Housekeeping and Done-Queue Delay Unit

This block performs the bookkeeping a USB host controller needs at every frame boundary. Each pulse on `frame_tick` advances a 16-bit frame counter and copies the frame-interval toggle into the frame-remaining toggle. In the cycle that follows, it asks for the new frame number to be stored in the shared communication area in memory. When the periodic list is enabled at that boundary, it also starts list processing.

The block also owns the interrupt-delay countdown for the done queue. Each retired transfer descriptor offers its 3-bit delay field, and that field can only shorten the countdown, never lengthen it. When a frame boundary finds the countdown at zero and the writeback-done status clear, the block requests a done-head writeback. It then sets the status, returns the countdown to its idle value and raises an interrupt if that source is enabled. Software clears the status to allow the next writeback.

Top module: `frame_hk_top`

## Requirements
- R1: On each cycle with `frame_tick` high, `frame_num` increments by one and wraps from 0xFFFF to 0. It holds its value on every other cycle.
- R2: On each cycle with `frame_tick` high, `frm_toggle` takes the value of `ival_toggle` and keeps it until the next tick.
- R3: `frm_wr_vld` is high for exactly the one cycle after each tick, and `frm_wr_data` then carries the new frame number in little-endian byte lanes: bits 7:0 hold the low byte and bits 15:8 the high byte.
- R4: On a cycle with `retire_vld` high, `retire_dly` replaces the countdown only if it is smaller than the value the countdown would otherwise take. A larger or equal field leaves the countdown unchanged.
- R5: The countdown (`dly_cnt`) decrements by one on each tick while it is between 1 and 6. The value 7 means idle and holds. The value 0 holds until a writeback happens.
- R6: A tick that sees `dly_cnt` equal to 0 and `wb_done` low produces a one-cycle `dh_wr_vld` in the next cycle. In that same cycle `wb_done` is 1 and `dly_cnt` is 7, or the field of a descriptor retired on the tick cycle if that field is smaller.
- R7: While `wb_done` is 1, a countdown at 0 produces no writeback. After `wb_done_clr` clears the status, the next tick writes back. If a set and a clear happen in the same cycle, the set wins.
- R8: `irq` rises together with `dh_wr_vld` when `irq_en` was high on the tick cycle, and stays high until `wb_done_clr`. A writeback with `irq_en` low leaves `irq` unchanged.
- R9: `list_run` is high for one cycle after a tick only when `list_en` was high on that tick.
- R10: After reset, `frame_num` is 0, `wb_done` is 0, `dly_cnt` is 7, `irq` is 0, and no request output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | Frame boundary pulse |
| ival_toggle | input | 1 | Frame-interval toggle bit |
| list_en | input | 1 | Periodic list enable |
| retire_vld | input | 1 | Descriptor retired this cycle |
| retire_dly | input | 3 | Delay field of the retired descriptor |
| wb_done_clr | input | 1 | Software clear of writeback-done status |
| irq_en | input | 1 | Writeback interrupt enable |
| frame_num | output | 16 | Current frame number |
| frm_toggle | output | 1 | Frame-remaining toggle bit |
| frm_wr_vld | output | 1 | Request to store frame number in shared area |
| frm_wr_data | output | 16 | Frame number, little-endian byte lanes |
| list_run | output | 1 | Start periodic list processing |
| dly_cnt | output | 3 | Interrupt-delay countdown |
| dh_wr_vld | output | 1 | Request to write back the done head |
| wb_done | output | 1 | Writeback-done status |
| irq | output | 1 | Interrupt request |

## Verification
The bound checker checks on every cycle that the frame number steps only on ticks, that the toggle copies its source, and that the store request follows each tick. It also checks that a retirement never leaves the countdown above the retired field, that a writeback happens only from a zero countdown with the status clear, and that the interrupt rises only together with a writeback. The bench scenarios cover the rest. They show the exact countdown sequence across several frames, the blocked writeback while the status is set and the release after a clear, same-cycle collisions between retire, tick and clear, the interrupt-enable gating, and the 16-bit wrap after 65536 ticks.

// File: rtl/frame_hk_pkg.sv
package frame_hk_pkg;
    localparam int unsigned FN_W_DEF  = 16;
    localparam int unsigned DLY_W_DEF = 3;
endpackage

// File: rtl/fhk_frame_ctr.sv
module fhk_frame_ctr #(
    parameter int unsigned FN_W = frame_hk_pkg::FN_W_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            ival_toggle,
    input  logic            list_en,
    output logic [FN_W-1:0] fn,
    output logic            frt,
    output logic            wr_vld,
    output logic [FN_W-1:0] wr_data,
    output logic            list_run
);
    localparam int unsigned NBYTES = (FN_W + 7) / 8;

    typedef struct packed {
        logic [FN_W-1:0] fn;
        logic            frt;
        logic            wr_vld;
        logic            list_run;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.wr_vld   = 1'b0;
        st_d.list_run = 1'b0;
        if (tick) begin
            st_d.fn       = st_q.fn + 1'b1;
            st_d.frt      = ival_toggle;
            st_d.wr_vld   = 1'b1;
            st_d.list_run = list_en;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // byte lane k of the store data carries byte k of the number (low byte first)
    for (genvar k = 0; k < NBYTES; k++) begin : g_lane
        localparam int unsigned LO = 8 * k;
        localparam int unsigned HI = (8 * k + 7 < FN_W) ? 8 * k + 7 : FN_W - 1;
        assign wr_data[HI:LO] = st_q.fn[HI:LO];
    end

    assign fn       = st_q.fn;
    assign frt      = st_q.frt;
    assign wr_vld   = st_q.wr_vld;
    assign list_run = st_q.list_run;
endmodule

// File: rtl/fhk_delay.sv
module fhk_delay #(
    parameter int unsigned DLY_W = frame_hk_pkg::DLY_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             fire,
    input  logic             retire_vld,
    input  logic [DLY_W-1:0] retire_dly,
    output logic [DLY_W-1:0] dly,
    output logic             dly_zero
);
    localparam logic [DLY_W-1:0] IDLE = {DLY_W{1'b1}};

    typedef struct packed {
        logic [DLY_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [DLY_W-1:0] base;

    always_comb begin
        base = st_q.cnt;
        if (fire) begin
            base = IDLE;
        end else if (tick && st_q.cnt != '0 && st_q.cnt != IDLE) begin
            base = st_q.cnt - 1'b1;
        end
        st_d = st_q;
        st_d.cnt = base;
        if (retire_vld && retire_dly < base) begin
            st_d.cnt = retire_dly;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign dly      = st_q.cnt;
    assign dly_zero = (st_q.cnt == '0);
endmodule

// File: rtl/fhk_wb_ctrl.sv
module fhk_wb_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic dly_zero,
    input  logic clr,
    input  logic ien,
    output logic fire,
    output logic dh_wr_vld,
    output logic wb_done,
    output logic irq
);
    typedef struct packed {
        logic dh_wr_vld;
        logic wb_done;
        logic irq;
    } st_t;

    st_t st_d, st_q;

    assign fire = tick && dly_zero && !st_q.wb_done;

    always_comb begin
        st_d           = st_q;
        st_d.dh_wr_vld = fire;
        if (fire) begin
            st_d.wb_done = 1'b1;
        end else if (clr) begin
            st_d.wb_done = 1'b0;
        end
        if (fire && ien) begin
            st_d.irq = 1'b1;
        end else if (clr) begin
            st_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dh_wr_vld = st_q.dh_wr_vld;
    assign wb_done   = st_q.wb_done;
    assign irq       = st_q.irq;
endmodule

// File: rtl/frame_hk_top.sv
module frame_hk_top #(
    parameter int unsigned FN_W  = frame_hk_pkg::FN_W_DEF,
    parameter int unsigned DLY_W = frame_hk_pkg::DLY_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_tick,
    input  logic             ival_toggle,
    input  logic             list_en,
    input  logic             retire_vld,
    input  logic [DLY_W-1:0] retire_dly,
    input  logic             wb_done_clr,
    input  logic             irq_en,
    output logic [FN_W-1:0]  frame_num,
    output logic             frm_toggle,
    output logic             frm_wr_vld,
    output logic [FN_W-1:0]  frm_wr_data,
    output logic             list_run,
    output logic [DLY_W-1:0] dly_cnt,
    output logic             dh_wr_vld,
    output logic             wb_done,
    output logic             irq
);
    logic fire;
    logic dly_zero;

    fhk_frame_ctr #(.FN_W(FN_W)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (frame_tick),
        .ival_toggle(ival_toggle),
        .list_en    (list_en),
        .fn         (frame_num),
        .frt        (frm_toggle),
        .wr_vld     (frm_wr_vld),
        .wr_data    (frm_wr_data),
        .list_run   (list_run)
    );

    fhk_delay #(.DLY_W(DLY_W)) u_delay (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (frame_tick),
        .fire      (fire),
        .retire_vld(retire_vld),
        .retire_dly(retire_dly),
        .dly       (dly_cnt),
        .dly_zero  (dly_zero)
    );

    fhk_wb_ctrl u_wb (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (frame_tick),
        .dly_zero (dly_zero),
        .clr      (wb_done_clr),
        .ien      (irq_en),
        .fire     (fire),
        .dh_wr_vld(dh_wr_vld),
        .wb_done  (wb_done),
        .irq      (irq)
    );
endmodule

// File: rtl/frame_hk_chk.sv
module frame_hk_chk #(
    parameter int unsigned FN_W  = 16,
    parameter int unsigned DLY_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_tick,
    input logic             ival_toggle,
    input logic             list_en,
    input logic             retire_vld,
    input logic [DLY_W-1:0] retire_dly,
    input logic             irq_en,
    input logic [FN_W-1:0]  frame_num,
    input logic             frm_toggle,
    input logic             frm_wr_vld,
    input logic [FN_W-1:0]  frm_wr_data,
    input logic             list_run,
    input logic [DLY_W-1:0] dly_cnt,
    input logic             dh_wr_vld,
    input logic             wb_done,
    input logic             irq
);
    AST_FN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        frame_tick |=> frame_num == $past(frame_num) + 1'b1); // R1
    AST_FN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_tick |=> $stable(frame_num)); // R1
    AST_TOGGLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        frame_tick |=> frm_toggle == $past(ival_toggle)); // R2
    AST_FRAME_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_tick |=> frm_wr_vld && frm_wr_data == frame_num); // R3
    AST_STORE_ONLY_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        frm_wr_vld |-> $past(frame_tick)); // R3
    AST_DLY_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        retire_vld |=> dly_cnt <= $past(retire_dly)); // R4
    AST_WB_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        dh_wr_vld |-> $past(frame_tick && dly_cnt == '0 && !wb_done)); // R6
    AST_WB_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        dh_wr_vld |-> wb_done); // R7
    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> dh_wr_vld && $past(irq_en)); // R8
    AST_LIST_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        list_run |-> $past(frame_tick && list_en)); // R9
endmodule

bind frame_hk_top frame_hk_chk #(.FN_W(FN_W), .DLY_W(DLY_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_tick (frame_tick),
    .ival_toggle(ival_toggle),
    .list_en    (list_en),
    .retire_vld (retire_vld),
    .retire_dly (retire_dly),
    .irq_en     (irq_en),
    .frame_num  (frame_num),
    .frm_toggle (frm_toggle),
    .frm_wr_vld (frm_wr_vld),
    .frm_wr_data(frm_wr_data),
    .list_run   (list_run),
    .dly_cnt    (dly_cnt),
    .dh_wr_vld  (dh_wr_vld),
    .wb_done    (wb_done),
    .irq        (irq)
);

// File: tb/tb_frame_hk_top.sv
module tb_frame_hk_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_tick = 1'b0;
    logic        ival_toggle = 1'b0;
    logic        list_en = 1'b0;
    logic        retire_vld = 1'b0;
    logic [2:0]  retire_dly = '0;
    logic        wb_done_clr = 1'b0;
    logic        irq_en = 1'b0;
    logic [15:0] frame_num;
    logic        frm_toggle;
    logic        frm_wr_vld;
    logic [15:0] frm_wr_data;
    logic        list_run;
    logic [2:0]  dly_cnt;
    logic        dh_wr_vld;
    logic        wb_done;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done_flag = 1'b0;

    // expected-state model
    logic [15:0] m_fn = '0;
    logic [2:0]  m_dly = 3'd7;
    logic        m_wbd = 1'b0;
    logic        m_irq = 1'b0;
    logic        m_dh = 1'b0;
    logic        m_lr = 1'b0;
    logic        m_frt = 1'b0;
    logic [15:0] exp_q[$];

    always #2.5 clk = ~clk;

    frame_hk_top dut (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .ival_toggle(ival_toggle),
        .list_en(list_en), .retire_vld(retire_vld), .retire_dly(retire_dly),
        .wb_done_clr(wb_done_clr), .irq_en(irq_en), .frame_num(frame_num),
        .frm_toggle(frm_toggle), .frm_wr_vld(frm_wr_vld), .frm_wr_data(frm_wr_data),
        .list_run(list_run), .dly_cnt(dly_cnt), .dh_wr_vld(dh_wr_vld),
        .wb_done(wb_done), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops expected frame-store values as the design issues them (R3)
    always @(negedge clk) begin
        if (rst_n && frm_wr_vld) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R3 actual=%0h expected=none", frm_wr_data);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                if (frm_wr_data[7:0] !== e[7:0] || frm_wr_data[15:8] !== e[15:8]) begin
                    n_fail++;
                    $display("FAIL R3 actual=%0h expected=%0h", frm_wr_data, e);
                end
            end
        end
    end

    // one cycle: drive at negedge, update the model, sample at the next negedge
    task automatic step(input bit tk, input bit iv, input bit le, input bit rv,
                        input logic [2:0] rd, input bit clr, input bit ie, input bit check);
        bit fire;
        logic [2:0] base;
        frame_tick = tk; ival_toggle = iv; list_en = le;
        retire_vld = rv; retire_dly = rd; wb_done_clr = clr; irq_en = ie;
        fire = tk && m_dly == 3'd0 && !m_wbd;
        if (fire) base = 3'd7;
        else if (tk && m_dly != 3'd0 && m_dly != 3'd7) base = m_dly - 3'd1;
        else base = m_dly;
        if (rv && rd < base) base = rd;
        m_dly = base;
        m_irq = (fire && ie) ? 1'b1 : (clr ? 1'b0 : m_irq);
        m_wbd = fire ? 1'b1 : (clr ? 1'b0 : m_wbd);
        m_dh  = fire;
        m_lr  = tk && le;
        if (tk) begin
            m_fn  = m_fn + 16'd1;
            m_frt = iv;
            exp_q.push_back(m_fn);
        end
        @(posedge clk);
        @(negedge clk);
        frame_tick = 1'b0; retire_vld = 1'b0; wb_done_clr = 1'b0;
        if (check) begin
            chk("R1", frame_num, m_fn);
            chk("R2", frm_toggle, m_frt);
            chk("R3", frm_wr_vld, tk);
            chk("R5", dly_cnt, m_dly);
            chk("R6", dh_wr_vld, m_dh);
            chk("R7", wb_done, m_wbd);
            chk("R8", irq, m_irq);
            chk("R9", list_run, m_lr);
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done_flag) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        chk("R10", frame_num, 16'd0);
        chk("R10", wb_done, 1'b0);
        chk("R10", dly_cnt, 3'd7);
        chk("R10", irq, 1'b0);
        chk("R10", {frm_wr_vld, dh_wr_vld, list_run}, 3'b000);

        // R1/R2/R9: ticks with varying toggle and list enable, idle gaps
        step(1, 1, 1, 0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0, 0, 0, 1);
        step(1, 0, 0, 0, 0, 0, 0, 1);
        step(1, 1, 1, 0, 0, 0, 0, 1);
        // R5: idle counter 7 holds across ticks
        step(1, 0, 0, 0, 0, 0, 1, 1);

        // R4: retire 3 shortens, then retire 5 does not lengthen, then 1 shortens
        step(0, 0, 0, 1, 3'd3, 0, 1, 1);
        step(0, 0, 0, 1, 3'd5, 0, 1, 1);
        chk("R4", dly_cnt, 3'd3);
        step(1, 0, 0, 0, 0, 0, 1, 1);   // 3 -> 2 (R5)
        step(0, 0, 0, 1, 3'd1, 0, 1, 1);
        chk("R4", dly_cnt, 3'd1);
        step(1, 0, 0, 0, 0, 0, 1, 1);   // 1 -> 0
        step(0, 0, 0, 0, 0, 0, 1, 1);
        chk("R5", dly_cnt, 3'd0);        // zero holds without tick
        // R6/R8: writeback with interrupt enabled
        step(1, 0, 0, 0, 0, 0, 1, 1);
        chk("R6", dh_wr_vld, 1'b1);
        chk("R8", irq, 1'b1);

        // R7: second queue reaches 0 while status is set -> blocked
        step(0, 0, 0, 1, 3'd0, 0, 1, 1);
        step(1, 0, 0, 0, 0, 0, 1, 1);
        chk("R7", dh_wr_vld, 1'b0);
        step(1, 0, 0, 0, 0, 0, 1, 1);
        chk("R7", dly_cnt, 3'd0);
        // clear status (irq drops), then next tick writes back with irq disabled
        step(0, 0, 0, 0, 0, 1, 0, 1);
        chk("R8", irq, 1'b0);
        step(1, 0, 0, 0, 0, 0, 0, 1);
        chk("R6", dh_wr_vld, 1'b1);
        chk("R8", irq, 1'b0);

        // R6/R4 collision: retire on the writeback tick keeps the smaller field
        step(0, 0, 0, 0, 0, 1, 1, 1);
        step(0, 0, 0, 1, 3'd0, 0, 1, 1);
        step(1, 0, 0, 1, 3'd2, 0, 1, 1);
        chk("R6", dly_cnt, 3'd2);
        // R7: clear on the same cycle as a writeback -> set wins
        step(1, 0, 0, 0, 0, 0, 1, 1);    // 2 -> 1
        step(1, 0, 0, 0, 0, 1, 1, 1);    // 1 -> 0, status cleared
        step(1, 0, 0, 0, 0, 1, 1, 1);    // fire with clear
        chk("R7", wb_done, 1'b1);

        // R1 wrap: run ticks back to back until frame number wraps
        begin
            int left;
            left = 65536 - int'(m_fn) + 2;
            for (int i = 0; i < left; i++) begin
                step(1, i[0], 0, 0, 0, 0, 0, (m_fn >= 16'hFFFD || m_fn <= 16'd1));
            end
        end
        chk("R1", frame_num, 16'd2);
        step(0, 0, 0, 0, 0, 0, 0, 1);
        chk("R3", exp_q.size(), 0);

        done_flag = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule